// File: doc/BRIEF.md
# Serial Control Register Port

This block is the host-facing side of a modem's configuration port. A host selects one of four modes with two level-sensitive inputs: a register-select line and a direction line. Two of the modes belong to the modem's data paths, which are handled elsewhere; the other two give the host serial access to a 24-bit control register. The modem is always the clock master. It drives a bit clock to the host, derived from the system clock by a parameterised divider.

In the write mode, the host presents serial data that the block samples on each rising edge of the bit clock, most significant bit first. The sampled bits go into a shift register that holds only the most recent 24 bits. The visible control register takes the shift-register contents only when the register-select line drops at the end of a write access. In the read mode, the block shifts the current register contents out on the receive-data line, most significant bit first. The register value feeds the rest of the modem through a parallel output, and the registered mode is also exported for the data paths.

Top module: `ctlreg_serial_port`

## Requirements
- R1: `mode_o` equals `{sel_i, dir_i}` one clock after those inputs are sampled. The codes are 2'b00 transmit, 2'b01 receive, 2'b10 register write and 2'b11 register read.
- R2: After synchronous reset, `ctrl_o` equals `RST_VAL`, `bclk_o` and `rxd_o` are low, and `mode_o` is 2'b01 (receive).
- R3: In transmit, write and read modes, `bclk_o` starts low and toggles every `DIV_HALF` system clocks. In receive mode it is held low. Any mode change returns it low and restarts the divider.
- R4: In write mode, `txd_i` is captured at each clock edge where `bclk_o` goes high. Bits arrive most significant first, so the last bit written lands in bit 0.
- R5: When more than 24 bits are written in one access, only the last 24 are kept.
- R6: `ctrl_o` does not change during an access. It takes the shift-register value in the cycle where the registered mode leaves write because `sel_i` went low.
- R7: A write access with fewer than 24 bits commits a right-aligned value. The upper bits come from the previous contents of the shift register.
- R8: On entry to read mode, `rxd_o` shows bit 23 of the register. Each falling edge of `bclk_o` advances it to the next lower bit, so the line is stable at rising edges. After bit 0 it wraps back to bit 23.
- R9: A read directly after reset returns `RST_VAL`. Ending a read access leaves `ctrl_o` unchanged.
- R10: Outside read mode, `rxd_o` is low. `txd_i` outside write mode has no effect on the shift register or on `ctrl_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Register-select level |
| dir_i | input | 1 | Direction level (1 = toward host) |
| txd_i | input | 1 | Serial data from host |
| bclk_o | output | 1 | Bit clock driven to host |
| rxd_o | output | 1 | Serial register data to host |
| mode_o | output | 2 | Registered mode code |
| ctrl_o | output | 24 | Committed control register |

## Verification
The hardest case to reach from the ports is the partial-write commit. Its result depends on shift-register bits left by an earlier access, and the shift register is not visible at the ports. The stimulus first writes a 28-bit stream to fix the shift contents, then writes eight bits and checks the right-aligned merge. Whether `txd_i` is ignored outside write mode is checked the same way. A zero-edge write access makes the untouched shift register visible on `ctrl_o`, and the bench runs it after a burst of `txd_i` toggling in transmit mode. A behavioural reference model, updated on every clock, covers the divider and the read wrap across all mode changes.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  typedef enum logic [1:0] {
    MODE_TX = 2'b00,
    MODE_RX = 2'b01,
    MODE_WR = 2'b10,
    MODE_RD = 2'b11
  } mode_e;

  function automatic mode_e to_mode(input logic sel, input logic dir);
    return mode_e'({sel, dir});
  endfunction
endpackage

// File: rtl/ctlreg_mode_decode.sv
module ctlreg_mode_decode
  import ctlreg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  sel_i,
  input  logic  dir_i,
  output mode_e mode_q_o,
  output mode_e mode_nxt_o,
  output logic  change_o
);
  mode_e mode_q;

  always_comb begin
    mode_nxt_o = to_mode(sel_i, dir_i);
    change_o   = (mode_nxt_o != mode_q);
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_RX;
    else     mode_q <= mode_nxt_o;
  end

  assign mode_q_o = mode_q;
endmodule

// File: rtl/ctlreg_bitclk.sv
module ctlreg_bitclk #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic bclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          bclk_q;
  logic          wrap;

  assign wrap   = (cnt_q == LAST);
  assign rise_o = run_i & wrap & ~bclk_q;
  assign fall_o = run_i & wrap & bclk_q;
  assign bclk_o = bclk_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // R3: divider idle forces the clock low; mid-count it holds its level
  a_r3_idle_low: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !bclk_q);
  a_r3_half_hold: assert property (@(posedge clk) disable iff (rst)
    (run_i && !wrap) |=> $stable(bclk_q));
endmodule

// File: rtl/ctlreg_shift_core.sv
module ctlreg_shift_core
  import ctlreg_pkg::*;
#(
  parameter int          W       = 24,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  mode_e        mode_q_i,
  input  mode_e        mode_nxt_i,
  input  logic         change_i,
  input  logic         txd_i,
  input  logic         rise_i,
  input  logic         fall_i,
  output logic [W-1:0] ctrl_o,
  output logic         rxd_o
);
  logic [W-1:0] wsh_q;
  logic [W-1:0] rsh_q;
  logic [W-1:0] ctrl_q;
  logic         rxd_q;
  logic         cap, commit, rd_enter, rd_step;

  always_comb begin
    cap      = (mode_q_i == MODE_WR) && !change_i && rise_i;
    commit   = (mode_q_i == MODE_WR) && !mode_nxt_i[1];
    rd_enter = change_i && (mode_nxt_i == MODE_RD);
    rd_step  = (mode_q_i == MODE_RD) && !change_i && fall_i;
  end

  // write path: keeps only the newest W bits
  always_ff @(posedge clk) begin
    if (rst)      wsh_q <= RST_VAL;
    else if (cap) wsh_q <= {wsh_q[W-2:0], txd_i};
  end

  always_ff @(posedge clk) begin
    if (rst)         ctrl_q <= RST_VAL;
    else if (commit) ctrl_q <= wsh_q;
  end

  // read path: rotating copy, line advances on bit-clock falls
  always_ff @(posedge clk) begin
    if (rst) begin
      rsh_q <= '0;
      rxd_q <= 1'b0;
    end else if (rd_enter) begin
      rsh_q <= ctrl_q;
      rxd_q <= ctrl_q[W-1];
    end else if (change_i) begin
      rxd_q <= 1'b0;
    end else if (rd_step) begin
      rsh_q <= {rsh_q[W-2:0], rsh_q[W-1]};
      rxd_q <= rsh_q[W-2];
    end
  end

  assign ctrl_o = ctrl_q;
  assign rxd_o  = rxd_q;

  a_r4_capture: assert property (@(posedge clk) disable iff (rst)
    cap |=> wsh_q == {$past(wsh_q[W-2:0]), $past(txd_i)});
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(ctrl_q));
  a_r6_commit: assert property (@(posedge clk) disable iff (rst)
    commit |=> ctrl_q == $past(wsh_q));
  a_r8_first_bit: assert property (@(posedge clk) disable iff (rst)
    rd_enter |=> rxd_q == $past(ctrl_q[W-1]));
  a_r10_rxd_idle: assert property (@(posedge clk) disable iff (rst)
    (mode_q_i != MODE_RD) |-> !rxd_q);
endmodule

// File: rtl/ctlreg_serial_port.sv
module ctlreg_serial_port
  import ctlreg_pkg::*;
#(
  parameter int           W        = 24,
  parameter int           DIV_HALF = 4,
  parameter logic [W-1:0] RST_VAL  = 24'h5A0FC3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel_i,
  input  logic         dir_i,
  input  logic         txd_i,
  output logic         bclk_o,
  output logic         rxd_o,
  output logic [1:0]   mode_o,
  output logic [W-1:0] ctrl_o
);
  mode_e mode_q, mode_nxt;
  logic  change, run, rise, fall;

  ctlreg_mode_decode u_dec (
    .clk        (clk),
    .rst        (rst),
    .sel_i      (sel_i),
    .dir_i      (dir_i),
    .mode_q_o   (mode_q),
    .mode_nxt_o (mode_nxt),
    .change_o   (change)
  );

  assign run = !change && (mode_q != MODE_RX);

  ctlreg_bitclk #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk    (clk),
    .rst    (rst),
    .run_i  (run),
    .bclk_o (bclk_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  ctlreg_shift_core #(.W(W), .RST_VAL(RST_VAL)) u_core (
    .clk        (clk),
    .rst        (rst),
    .mode_q_i   (mode_q),
    .mode_nxt_i (mode_nxt),
    .change_i   (change),
    .txd_i      (txd_i),
    .rise_i     (rise),
    .fall_i     (fall),
    .ctrl_o     (ctrl_o),
    .rxd_o      (rxd_o)
  );

  assign mode_o = mode_q;

  a_r1_mode_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> mode_o == $past({sel_i, dir_i}));
  a_r3_rx_clock_low: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'b01) |-> !bclk_o);
endmodule

// File: tb/ctlreg_serial_port_tb.sv
module ctlreg_serial_port_tb;
  localparam int          W   = 24;
  localparam int          H   = 4;
  localparam logic [23:0] RSV = 24'h5A0FC3;

  logic clk = 1'b0, rst = 1'b1, sel = 1'b0, dir = 1'b1, txd = 1'b0;
  logic bclk, rxd;
  logic [1:0]  mode;
  logic [23:0] ctrl;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  ctlreg_serial_port #(.W(W), .DIV_HALF(H), .RST_VAL(RSV)) u_dut (
    .clk(clk), .rst(rst), .sel_i(sel), .dir_i(dir), .txd_i(txd),
    .bclk_o(bclk), .rxd_o(rxd), .mode_o(mode), .ctrl_o(ctrl)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_mode, m_cnt, m_rdi;
  bit m_bclk, m_rxd;
  bit [23:0] m_sh, m_ctrl;
  always @(posedge clk) begin
    if (rst) begin
      m_mode = 1; m_cnt = 0; m_bclk = 0; m_sh = RSV; m_ctrl = RSV; m_rdi = 0; m_rxd = 0;
    end else begin
      int nm; bit same, run, edg;
      nm   = {sel, dir};
      same = (nm == m_mode);
      run  = same && (m_mode != 1);
      edg  = run && (m_cnt == H - 1);
      if (m_mode == 2 && !sel) m_ctrl = m_sh;
      if (edg && !m_bclk && m_mode == 2) m_sh = {m_sh[22:0], txd};
      if (!same && nm == 3) begin m_rdi = 23; m_rxd = m_ctrl[23]; end
      else if (!same) m_rxd = 0;
      else if (edg && m_bclk && m_mode == 3) begin m_rdi = (m_rdi + 23) % 24; m_rxd = m_ctrl[m_rdi]; end
      if (!run) begin m_cnt = 0; m_bclk = 0; end
      else if (m_cnt == H - 1) begin m_cnt = 0; m_bclk = !m_bclk; end
      else m_cnt++;
      m_mode = nm;
    end
  end

  always @(negedge clk) if (!rst) begin
    chk("R1 mode", {30'd0, mode}, m_mode[1:0]);
    chk("R3 bclk", {31'd0, bclk}, {31'd0, m_bclk});
    chk("R8 rxd", {31'd0, rxd}, {31'd0, m_rxd});
    chk("R6 ctrl", {8'd0, ctrl}, {8'd0, m_ctrl});
  end

  task automatic wr_access(input logic [31:0] bits, input int n, input bit peek);
    @(negedge clk); sel = 1; dir = 0; txd = bits[n-1];
    for (int i = n - 1; i >= 0; i--) begin
      @(posedge bclk); @(negedge clk);
      if (i > 0) txd = bits[i-1];
    end
    if (peek) chk("R6 unchanged before select falls", {8'd0, ctrl}, {8'd0, m_ctrl});
    sel = 0; dir = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd_access(input int n, output logic [31:0] v);
    v = 0;
    @(negedge clk); sel = 1; dir = 1;
    for (int i = 0; i < n; i++) begin
      @(posedge bclk); @(negedge clk);
      v = {v[30:0], rxd};
    end
    sel = 0; dir = 1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int t0, t1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R2 reset state
    chk("R2 ctrl", {8'd0, ctrl}, {8'd0, RSV});
    chk("R2 bclk", {31'd0, bclk}, 0);
    chk("R2 rxd", {31'd0, rxd}, 0);
    chk("R2 mode", {30'd0, mode}, 32'd1);
    // R9 read after reset
    rd_access(24, v);
    chk("R9 read after reset", v, {8'd0, RSV});
    chk("R9 ctrl kept after read", {8'd0, ctrl}, {8'd0, RSV});
    // R3 receive mode keeps clock low
    t0 = 0;
    repeat (20) begin @(negedge clk); if (bclk) t0++; end
    chk("R3 receive clock low", t0, 0);
    // R3 period in transmit mode; R10 rxd low while txd toggles
    @(negedge clk); sel = 0; dir = 0;
    @(posedge bclk); t0 = $time;
    @(posedge bclk); t1 = $time;
    chk("R3 period", t1 - t0, 2 * H * 8);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); txd = i[0];
      if (rxd) chk("R10 rxd low in transmit", {31'd0, rxd}, 0);
    end
    chk("R10 ctrl after transmit", {8'd0, ctrl}, {8'd0, RSV});
    // R1 all four codes
    @(negedge clk); sel = 1; dir = 0; @(negedge clk);
    chk("R1 write code", {30'd0, mode}, 32'd2);
    sel = 1; dir = 1; @(negedge clk);
    chk("R1 read code", {30'd0, mode}, 32'd3);
    sel = 0; dir = 0; @(negedge clk);
    chk("R1 transmit code", {30'd0, mode}, 32'd0);
    sel = 0; dir = 1; @(negedge clk);
    chk("R1 receive code", {30'd0, mode}, 32'd1);
    // R4 full write
    wr_access(32'h00A53C96, 24, 1);
    chk("R4 full write", {8'd0, ctrl}, 32'h00A53C96);
    // R5 overlong write keeps last 24
    wr_access(32'hF123456, 28, 1);
    chk("R5 last 24 kept", {8'd0, ctrl}, 32'h00123456);
    // R7 partial write
    wr_access(32'hC9, 8, 0);
    chk("R7 partial merge", {8'd0, ctrl}, 32'h003456C9);
    // R10 txd in transmit mode leaves shift register alone: zero-edge write
    @(negedge clk); sel = 0; dir = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); txd = ~txd; end
    sel = 1; dir = 0; @(negedge clk);
    sel = 0; dir = 1; repeat (2) @(negedge clk);
    chk("R10 shift untouched outside write", {8'd0, ctrl}, 32'h003456C9);
    // R8 read with wrap
    rd_access(26, v);
    chk("R8 read bits", v, {6'd0, 24'h3456C9, 2'b00});
    chk("R9 ctrl kept after read", {8'd0, ctrl}, 32'h003456C9);
    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule